// File: doc/BRIEF.md
# Serial Frame Port for a Converter

This block is the device-side serial port of a data converter. The host frames each transfer with an active-low select/convert-start line and supplies a serial clock. Command bits arrive on a serial input, and result bits leave on one or more output lanes. All host inputs are sampled on the system clock, and their edges are found by comparing each input with its value one cycle earlier.

When the select line falls and no conversion is running, a frame opens. At that point the block parallel-loads the current result word into an output shift register and clears its command register to zero, which means no-op. It also resets its serial-clock counter and drives the ready/busy output low. During the frame, each rising serial-clock edge shifts one input bit into the least significant end of the input register and increments the counter. Each falling serial-clock edge advances the output register, so the result leaves most significant bit first. Only the lanes the host selected drive data.

When the select line rises, the output lanes are released and the frame is classified by its clock count. A count of exactly one word width, or more, hands the last word-width bits received to the command decoder with a one-cycle valid strobe. A smaller count leaves the command as a no-op. A modelled conversion then holds ready/busy low for a fixed number of cycles. Ready/busy goes high when the conversion is done.

Top module: `sfi_port`

## Requirements
- R1: After reset, rvs_o is 1, sdo_oe_o is all zeros, cmd_o is 0 and cmd_valid_o is 0.
- R2: A falling edge of cs_n while the port is ready opens a frame. Within two system clocks, sdo_oe_o equals lane_en_i, rvs_o is 0, and every enabled lane shows bit 31 of result_i.
- R3: While the frame is open, each rising edge of sclk shifts sdi into bit 0 of the input register and increments the clock counter.
- R4: Each falling edge of sclk in an open frame shifts the output register left by one bit. After k falling edges, each enabled lane shows result bit 31-k, so data leaves most significant bit first. Lanes not enabled drive 0.
- R5: A frame with exactly 32 rising sclk edges ends with cmd_o equal to the 32 bits received, with the first bit received in bit 31. cmd_valid_o is high for exactly one system clock.
- R6: A frame with fewer than 32 rising sclk edges ends with cmd_o equal to 0 and no cmd_valid_o pulse.
- R7: A frame with more than 32 rising sclk edges ends with cmd_o equal to the last 32 bits received and one cmd_valid_o pulse.
- R8: When a frame opens, cmd_o is cleared to 0.
- R9: A rising edge of cs_n ends the frame. sdo_oe_o returns to 0, and rvs_o stays 0 for BUSY_CYC cycles and then returns to 1.
- R10: A falling edge of cs_n while the conversion is running is ignored. sdo_oe_o stays 0 and cmd_o is unchanged.
- R11: sclk edges while cs_n is high change neither the shift registers nor the clock counter.
- R12: The clock counter saturates and does not wrap. An 80-clock frame is treated as a long frame, not a short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select / convert start from host |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial command data from host |
| lane_en_i | input | LANES | Output lanes to drive in the next frame |
| result_i | input | WORD_W | Result word loaded at frame start |
| sdo_o | output | LANES | Serial result data per lane |
| sdo_oe_o | output | LANES | Per-lane output enable (0 = high impedance) |
| rvs_o | output | 1 | Ready (1) / busy or in frame (0) |
| cmd_o | output | WORD_W | Command word for the decoder |
| cmd_valid_o | output | 1 | One-cycle strobe marking a valid command |

## Verification
The bench targets the frame-length boundaries: 0, 1 and 31 clocks, exactly 32, 33 and 40. A design with an off-by-one in the comparison would accept a 31-clock write or drop a 32-clock one. An 80-clock frame exposes a counter that wraps instead of saturating, because 80 wraps to 16 and would be taken for a short frame. Serial clock toggles while select is high are followed by a 30-clock frame, which shows whether stray edges leaked into the count. A select pulse during the busy window checks that no frame starts while converting. Frames after a valid one check that the command register is cleared at frame start.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    typedef enum logic [1:0] {
        LEN_SHORT = 2'd0,
        LEN_EXACT = 2'd1,
        LEN_LONG  = 2'd2
    } frame_len_e;
endpackage

// File: rtl/sfi_edge.sv
module sfi_edge #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;
endmodule

// File: rtl/sfi_busy.sv
module sfi_busy #(
    parameter int BUSY_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = BW'(BUSY_CYC);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sfi_port.sv
module sfi_port #(
    parameter int WORD_W   = 32,
    parameter int LANES    = 2,
    parameter int BUSY_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [WORD_W-1:0] result_i,
    output logic [LANES-1:0]  sdo_o,
    output logic [LANES-1:0]  sdo_oe_o,
    output logic              rvs_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              cmd_valid_o
);
    import sfi_pkg::*;

    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

    typedef struct packed {
        logic              act;
        logic [WORD_W-1:0] osr;
        logic [WORD_W-1:0] isr;
        logic [WORD_W-1:0] cmd;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [LANES-1:0]  lanes;
    } port_st_t;

    port_st_t st_d, st_q;

    logic cs_rise, cs_fall, sck_rise, sck_fall;
    logic busy, busy_start;
    frame_len_e len;

    sfi_edge #(.INIT(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall)
    );

    sfi_edge #(.INIT(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sck_rise), .fall(sck_fall)
    );

    sfi_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy)
    );

    always_comb begin
        if (st_q.cnt == CNT_WORD)     len = LEN_EXACT;
        else if (st_q.cnt > CNT_WORD) len = LEN_LONG;
        else                          len = LEN_SHORT;
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        busy_start = 1'b0;
        if (!st_q.act) begin
            if (cs_fall && !busy) begin
                st_d.act   = 1'b1;
                st_d.osr   = result_i;
                st_d.isr   = '0;
                st_d.cnt   = '0;
                st_d.cmd   = '0;
                st_d.lanes = lane_en_i;
            end
        end else if (cs_n) begin
            st_d.act   = 1'b0;
            busy_start = 1'b1;
            unique case (len)
                LEN_EXACT, LEN_LONG: begin
                    st_d.cmd = st_q.isr;
                    st_d.vld = 1'b1;
                end
                default: st_d.cmd = '0;
            endcase
        end else begin
            if (sck_rise) begin
                st_d.isr = {st_q.isr[WORD_W-2:0], sdi};
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sck_fall) begin
                st_d.osr = {st_q.osr[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_oe_o    = st_q.lanes & {LANES{st_q.act}};
    assign sdo_o       = sdo_oe_o & {LANES{st_q.osr[WORD_W-1]}};
    assign rvs_o       = ~(st_q.act | busy);
    assign cmd_o       = st_q.cmd;
    assign cmd_valid_o = st_q.vld;
endmodule

// File: rtl/sfi_port_chk.sv
module sfi_port_chk #(
    parameter int WORD_W = 32,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic [LANES-1:0]  sdo_o,
    input logic [LANES-1:0]  sdo_oe_o,
    input logic              rvs_o,
    input logic [WORD_W-1:0] cmd_o,
    input logic              cmd_valid_o
);
    p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    p_oe_off_when_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (sdo_oe_o == '0));

    p_rvs_low_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o != '0) |-> !rvs_o);

    p_valid_starts_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !rvs_o);

    p_cmd_moves_only_legally_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> (cmd_valid_o || cmd_o == '0));

    p_lanes_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_o & ~sdo_oe_o) == '0);
endmodule

bind sfi_port sfi_port_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .rvs_o(rvs_o), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o)
);

// File: tb/sfi_port_test.sv
module sfi_port_test;
    localparam int W = 32;
    localparam int L = 2;
    localparam int BC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [L-1:0] lane_en = '1;
    logic [W-1:0] result = '0;
    logic [L-1:0] sdo, sdo_oe;
    logic rvs;
    logic [W-1:0] cmd;
    logic cmd_valid;

    int checks = 0;
    int fails = 0;
    int vld_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sfi_port #(.WORD_W(W), .LANES(L), .BUSY_CYC(BC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .lane_en_i(lane_en), .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .rvs_o(rvs), .cmd_o(cmd), .cmd_valid_o(cmd_valid)
    );

    always @(negedge clk) if (cmd_valid) vld_cnt++;

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_cmd(input int n, input logic [W-1:0] last);
        return (n >= W) ? last : '0;
    endfunction

    task automatic run_frame(input int n, input int stray);
        logic [W-1:0] last = '0;
        logic [L-1:0] le;
        for (int s = 0; s < stray; s++) begin
            sclk = 1'b1; clks(2); sclk = 1'b0; clks(2);
        end
        le = L'($urandom_range(1, (1 << L) - 1));
        lane_en = le;
        result = $urandom;
        vld_cnt = 0;
        cs_n = 1'b0;
        clks(2);
        chk("R2 oe", W'(sdo_oe), W'(le));
        chk("R2 rvs", W'(rvs), '0);
        chk("R8 cmd cleared", cmd, '0);
        for (int k = 0; k < n; k++) begin
            if (k < W) chk("R4 sdo msb-first", W'(sdo), W'(le & {L{result[W-1-k]}}));
            sdi = 1'($urandom);
            last = {last[W-2:0], sdi};
            clks(3); sclk = 1'b1; clks(3); sclk = 1'b0; clks(3);
        end
        cs_n = 1'b1;
        clks(3);
        if (n < W) chk("R6 short no-op", cmd, exp_cmd(n, last));
        else if (n == W) chk("R5 exact cmd", cmd, exp_cmd(n, last));
        else if (n == 80) chk("R12 saturate", cmd, exp_cmd(n, last));
        else chk("R7 long cmd", cmd, exp_cmd(n, last));
        chk("R3/R5/R6/R7 valid pulses", W'(vld_cnt), (n >= W) ? 1 : 0);
        chk("R9 oe off", W'(sdo_oe), '0);
        chk("R9 busy", W'(rvs), '0);
    endtask

    task automatic wait_ready();
        clks(BC + 2);
        chk("R9 ready", W'(rvs), 1);
    endtask

    initial begin
        logic [W-1:0] hold;
        void'($urandom(32'h5EED));
        clks(3);
        chk("R1 rvs", W'(rvs), 1);
        chk("R1 oe", W'(sdo_oe), '0);
        chk("R1 cmd", cmd, '0);
        chk("R1 valid", W'(cmd_valid), '0);
        rst_n = 1'b1;
        clks(2);
        run_frame(32, 0); wait_ready();
        run_frame(31, 0); wait_ready();
        run_frame(1, 0);  wait_ready();
        run_frame(0, 0);  wait_ready();
        run_frame(33, 0); wait_ready();
        run_frame(40, 0); wait_ready();
        run_frame(80, 0); wait_ready();
        // R11: stray clocks while deselected must not push a 30-clock frame past 31
        run_frame(30, 5); wait_ready();
        // R10: select pulse during the busy window is ignored
        run_frame(32, 0);
        hold = cmd;
        cs_n = 1'b0; clks(3);
        chk("R10 oe stays off", W'(sdo_oe), '0);
        chk("R10 cmd unchanged", cmd, hold);
        cs_n = 1'b1;
        wait_ready();
        for (int i = 0; i < 20; i++) begin
            run_frame($urandom_range(0, 70), $urandom_range(0, 2));
            wait_ready();
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule